// File: doc/BRIEF.md
# Operand Watch Break Comparator

This block is a debug watch unit with two channels that observe the data side of a processor. Each cycle in which the transfer strobe is high, every channel compares the operand address against its own programmed address under an address mask. In combined mode it also compares the transferred data against a programmed value under a data mask. A matching transfer produces a one-cycle break pulse on that channel one clock later and sets a sticky status bit that stays set until software clears it.

The data compare takes byte lanes into account with big-endian numbering: address bits [1:0] and the transfer size select which byte lanes were actually transferred. The block builds the mask for the lanes that were not transferred by itself and ORs it with the programmed data mask, so software only has to program the value it is looking for. Each channel's address comparator is tied to one data comparator of the same index, and this pairing cannot be changed.

The transfer inputs are a snoop of a bus the block does not own. They have no ready signal, the block never applies back-pressure, and every strobed transfer is evaluated in the cycle it appears. Configuration arrives through a write-only register port: one write per cycle, taking effect at the next clock edge.

Top module: `opbrk_unit`

## Requirements
- R1: While reset is held and immediately after it is released, `brk_pulse` and `brk_sticky` are all zero.
- R2: A qualifying transfer sampled on a clock edge with `xfer_valid` high raises `brk_pulse` for that channel for exactly one cycle, starting at the next edge. With `xfer_valid` low, no pulse is produced.
- R3: The address of channel i matches when `((xfer_addr ^ acmp_i) & ~amsk_i) == 0`. An address-mask bit of 1 excludes that address bit from the compare.
- R4: Channel i requires a data match only when mode is 2'b11, combine is 1, and both enables of channel i (address enable and data enable) are 1. In every other case with the address enable set, the address match alone triggers and the data registers have no effect.
- R5: Channel 0 pairs address comparator 0 with data comparator 0, and channel 1 pairs comparator 1 with data 1. The data value of the other channel never produces a match.
- R6: A programmed data-mask bit of 1 excludes that data bit from the compare.
- R7: Size 2'b00 (8-bit) compares one byte: offset 0 uses bits [31:24], offset 1 uses [23:16], offset 2 uses [15:8], offset 3 uses [7:0]. The other lanes are ignored.
- R8: Size 2'b01 (16-bit) compares bits [31:16] at offsets 0 and 1, and bits [15:0] at offsets 2 and 3.
- R9: Size 2'b10 (32-bit) compares all 32 bits at any offset. The reserved size 2'b11 is treated as 32-bit.
- R10: The direction field of each channel gates the trigger: bit 0 allows reads (`xfer_write`=0) and bit 1 allows writes. Value 2'b00 blocks the channel.
- R11: `brk_sticky[i]` is set whenever `brk_pulse[i]` rises. Writing 1 to bit i of the status register clears it. A hit in the same cycle as the clear wins, and writing 0 has no effect.
- R12: Register index map (`cfg_sel`):
  - 0: control. Bit 0 is address enable 0, bit 1 is data enable 0, bits [3:2] are direction 0. Bits 4, 5 and [7:6] are the same fields for channel 1. Bit 8 is combine and bits [10:9] are mode.
  - 1: status (write-1-clear).
  - 2 and 3: address compare for channels 0 and 1.
  - 4 and 5: address mask for channels 0 and 1.
  - 6 and 7: data value for channels 0 and 1.
  - 8 and 9: data mask for channels 0 and 1.
  - All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_valid | input | 1 | A data transfer is present this cycle |
| xfer_addr | input | AW | Operand byte address |
| xfer_data | input | DW | Data bus value, big-endian lanes |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| xfer_write | input | 1 | 1 for write, 0 for read |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SELW | Register index |
| cfg_wdata | input | DW | Register write data |
| brk_pulse | output | NCH | One-cycle break request per channel |
| brk_sticky | output | NCH | Sticky break status per channel |

## Verification
The bench builds the block with its defaults: two channels and 32-bit address and data. At this size every byte-lane offset, every halfword half and the reserved size code can be exercised exhaustively, and the fixed pairing can be tested by crossing one channel's data value with the other channel's address. With two channels, a clear of one status bit can be shown to leave the other untouched, and a clear that coincides with a hit can be driven directly. The widths keep the address-mask and data-mask cases small enough to state by hand.

// File: rtl/opbrk_pkg.sv
`timescale 1ns/1ps
package opbrk_pkg;

  // transfer size codes
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // mode value that enables paired address+data compare
  localparam logic [1:0] MODE_DATAVAL = 2'b11;

  // register index bases (channel i adds i)
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_ACMP = 2;

  // per-channel control fields
  typedef struct packed {
    logic [1:0] dir;  // bit1 writes allowed, bit0 reads allowed
    logic       den;  // data comparator enable
    logic       aen;  // address comparator enable
  } chan_ctl_t;

  localparam int CTL_BITS = 4;

endpackage

// File: rtl/opbrk_regs.sv
`timescale 1ns/1ps
module opbrk_regs
  import opbrk_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SELW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SELW-1:0]           cfg_sel,
  input  logic [DW-1:0]             cfg_wdata,
  output chan_ctl_t [NCH-1:0]       ctl,
  output logic                      combine,
  output logic [1:0]                mode,
  output logic [NCH-1:0][AW-1:0]    addr_cmp,
  output logic [NCH-1:0][AW-1:0]    addr_msk,
  output logic [NCH-1:0][DW-1:0]    data_val,
  output logic [NCH-1:0][DW-1:0]    data_msk,
  output logic [NCH-1:0]            sticky_clr
);

  localparam int AMSK_BASE = REG_ACMP + NCH;
  localparam int DVAL_BASE = REG_ACMP + 2 * NCH;
  localparam int DMSK_BASE = REG_ACMP + 3 * NCH;
  localparam int CMB_BIT   = CTL_BITS * NCH;

  logic hit_ctrl;
  assign hit_ctrl   = cfg_we && (cfg_sel == SELW'(REG_CTRL));
  assign sticky_clr = (cfg_we && (cfg_sel == SELW'(REG_STAT))) ? cfg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      combine  <= 1'b0;
      mode     <= 2'b00;
      addr_cmp <= '0;
      addr_msk <= '0;
      data_val <= '0;
      data_msk <= '0;
    end else begin
      if (hit_ctrl) begin
        for (int i = 0; i < NCH; i++) begin
          ctl[i].aen <= cfg_wdata[CTL_BITS*i];
          ctl[i].den <= cfg_wdata[CTL_BITS*i+1];
          ctl[i].dir <= cfg_wdata[CTL_BITS*i+2 +: 2];
        end
        combine <= cfg_wdata[CMB_BIT];
        mode    <= cfg_wdata[CMB_BIT+1 +: 2];
      end
      if (cfg_we) begin
        for (int i = 0; i < NCH; i++) begin
          if (cfg_sel == SELW'(REG_ACMP + i))  addr_cmp[i] <= cfg_wdata[AW-1:0];
          if (cfg_sel == SELW'(AMSK_BASE + i)) addr_msk[i] <= cfg_wdata[AW-1:0];
          if (cfg_sel == SELW'(DVAL_BASE + i)) data_val[i] <= cfg_wdata;
          if (cfg_sel == SELW'(DMSK_BASE + i)) data_msk[i] <= cfg_wdata;
        end
      end
    end
  end

endmodule

// File: rtl/opbrk_lanes.sv
`timescale 1ns/1ps
module opbrk_lanes
  import opbrk_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB   = DW / 8,
  localparam int OFFW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [1:0]      size,
  input  logic [OFFW-1:0] off,
  output logic [DW-1:0]   ign_mask   // 1 = lane not transferred
);

  // byte lane b counts from the most significant byte (big-endian)
  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int HI = DW - 1 - 8 * b;
    logic lane_on;
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_on = (off == OFFW'(b));
        SZ_HALF: lane_on = ((off >> 1) == OFFW'(b >> 1));
        default: lane_on = 1'b1;
      endcase
    end
    assign ign_mask[HI -: 8] = {8{~lane_on}};
  end

endmodule

// File: rtl/opbrk_chan.sv
`timescale 1ns/1ps
module opbrk_chan
  import opbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          xfer_valid,
  input  logic [AW-1:0] xfer_addr,
  input  logic [DW-1:0] xfer_data,
  input  logic          xfer_write,
  input  logic [DW-1:0] lane_ign,
  input  chan_ctl_t     ctl,
  input  logic          pair_mode,   // global combine qualifier
  input  logic [AW-1:0] addr_cmp,
  input  logic [AW-1:0] addr_msk,
  input  logic [DW-1:0] data_val,
  input  logic [DW-1:0] data_msk,
  output logic          hit
);

  logic addr_hit, data_hit, dir_ok, paired;

  assign addr_hit = ((xfer_addr ^ addr_cmp) & ~addr_msk) == '0;
  assign data_hit = ((xfer_data ^ data_val) & ~(data_msk | lane_ign)) == '0;
  assign dir_ok   = xfer_write ? ctl.dir[1] : ctl.dir[0];
  assign paired   = pair_mode & ctl.aen & ctl.den;
  assign hit      = xfer_valid & ctl.aen & dir_ok & addr_hit & (~paired | data_hit);

endmodule

// File: rtl/opbrk_unit.sv
`timescale 1ns/1ps
module opbrk_unit
  import opbrk_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int SELW = $clog2(2 + 4 * NCH),
  localparam int OFFW = (DW / 8 > 1) ? $clog2(DW / 8) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_valid,
  input  logic [AW-1:0]   xfer_addr,
  input  logic [DW-1:0]   xfer_data,
  input  logic [1:0]      xfer_size,
  input  logic            xfer_write,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [NCH-1:0]  brk_pulse,
  output logic [NCH-1:0]  brk_sticky
);

  chan_ctl_t [NCH-1:0]    ctl;
  logic                   combine;
  logic [1:0]             mode;
  logic [NCH-1:0][AW-1:0] addr_cmp, addr_msk;
  logic [NCH-1:0][DW-1:0] data_val, data_msk;
  logic [NCH-1:0]         sticky_clr;
  logic [DW-1:0]          lane_ign;
  logic [NCH-1:0]         hit;
  logic                   pair_mode;

  opbrk_regs #(.NCH(NCH), .AW(AW), .DW(DW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl(ctl), .combine(combine), .mode(mode),
    .addr_cmp(addr_cmp), .addr_msk(addr_msk), .data_val(data_val),
    .data_msk(data_msk), .sticky_clr(sticky_clr)
  );

  opbrk_lanes #(.DW(DW)) u_lanes (
    .size(xfer_size), .off(xfer_addr[OFFW-1:0]), .ign_mask(lane_ign)
  );

  assign pair_mode = combine && (mode == MODE_DATAVAL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    opbrk_chan #(.AW(AW), .DW(DW)) u_chan (
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_data(xfer_data),
      .xfer_write(xfer_write), .lane_ign(lane_ign), .ctl(ctl[i]),
      .pair_mode(pair_mode), .addr_cmp(addr_cmp[i]), .addr_msk(addr_msk[i]),
      .data_val(data_val[i]), .data_msk(data_msk[i]), .hit(hit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pulse  <= '0;
      brk_sticky <= '0;
    end else begin
      brk_pulse  <= hit;
      brk_sticky <= (brk_sticky & ~sticky_clr) | hit;  // a new hit beats a clear
    end
  end

endmodule

// File: rtl/opbrk_chk.sv
`timescale 1ns/1ps
module opbrk_chk
  import opbrk_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SELW = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   xfer_valid,
  input logic [AW-1:0]          xfer_addr,
  input logic                   xfer_write,
  input logic                   cfg_we,
  input logic [SELW-1:0]        cfg_sel,
  input logic [DW-1:0]          cfg_wdata,
  input logic [NCH-1:0]         brk_pulse,
  input logic [NCH-1:0]         brk_sticky,
  input chan_ctl_t [NCH-1:0]    ctl,
  input logic [NCH-1:0][AW-1:0] addr_cmp,
  input logic [NCH-1:0][AW-1:0] addr_msk
);

  assert_needs_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|brk_pulse) |-> $past(xfer_valid));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_addr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse[i] |-> $past(((xfer_addr ^ addr_cmp[i]) & ~addr_msk[i]) == '0));

    assert_dir_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse[i] |-> $past(xfer_write ? ctl[i].dir[1] : ctl[i].dir[0]));

    assert_sticky_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse[i] |-> brk_sticky[i]);

    assert_sticky_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk_sticky[i]) |->
        $past(cfg_we && (cfg_sel == SELW'(REG_STAT)) && cfg_wdata[i]));
  end

endmodule

bind opbrk_unit opbrk_chk #(.NCH(NCH), .AW(AW), .DW(DW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .xfer_write(xfer_write), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .brk_pulse(brk_pulse), .brk_sticky(brk_sticky),
  .ctl(ctl), .addr_cmp(addr_cmp), .addr_msk(addr_msk)
);

// File: tb/opbrk_unit_bench.sv
`timescale 1ns/1ps
module opbrk_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic [31:0] xfer_data = '0;
  logic [1:0]  xfer_size = 2'b10;
  logic        xfer_write = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  brk_pulse, brk_sticky;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  opbrk_unit u_opbrk_unit (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
    .xfer_data(xfer_data), .xfer_size(xfer_size), .xfer_write(xfer_write),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .brk_pulse(brk_pulse), .brk_sticky(brk_sticky)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  sz;
    logic        wr;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 16;
  // ch0: addr 0x1000/mask 3, data 0x11223344; ch1: addr 0x2000/mask 3, data 0xA5A55A5A mask 0xFF00
  localparam vec_t VEC [NV] = '{
    '{32'h1000, 32'h11223344, 2'b10, 1'b0, 2'b01},  // R9 word match
    '{32'h1000, 32'h11223345, 2'b10, 1'b1, 2'b00},  // R9 one bit off
    '{32'h1000, 32'h11FFFFFF, 2'b00, 1'b0, 2'b01},  // R7 byte off 0
    '{32'h1001, 32'h00220000, 2'b00, 1'b1, 2'b01},  // R7 byte off 1
    '{32'h1002, 32'h00003300, 2'b00, 1'b0, 2'b01},  // R7 byte off 2
    '{32'h1003, 32'h00000044, 2'b00, 1'b1, 2'b01},  // R7 byte off 3
    '{32'h1003, 32'h44000000, 2'b00, 1'b0, 2'b00},  // R7 wrong lane
    '{32'h1000, 32'h11220000, 2'b01, 1'b0, 2'b01},  // R8 upper half
    '{32'h1001, 32'h1122FFFF, 2'b01, 1'b1, 2'b01},  // R8 upper half, odd offset
    '{32'h1002, 32'h00003344, 2'b01, 1'b0, 2'b01},  // R8 lower half
    '{32'h1002, 32'h11220000, 2'b01, 1'b0, 2'b00},  // R8 lower half mismatch
    '{32'h1004, 32'h11223344, 2'b10, 1'b0, 2'b00},  // R3 address miss
    '{32'h2000, 32'hA5A5005A, 2'b10, 1'b1, 2'b10},  // R6 ch1 masked byte
    '{32'h2000, 32'h11223344, 2'b10, 1'b0, 2'b00},  // R5 ch0 data at ch1 address
    '{32'h1000, 32'hA5A55A5A, 2'b10, 1'b0, 2'b00},  // R5 ch1 data at ch0 address
    '{32'h2003, 32'h0000005A, 2'b00, 1'b0, 2'b10}   // R7 ch1 byte off 3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one transfer; on return the registered pulse is visible
  task automatic xfer(input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input logic w);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_addr = a; xfer_data = d; xfer_size = sz; xfer_write = w;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 pulse in reset", {30'd0, brk_pulse}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sticky after reset", {30'd0, brk_sticky}, 32'd0);
    chk("R1 pulse after reset", {30'd0, brk_pulse}, 32'd0);

    // R12 register map
    wr_reg(4'd2, 32'h1000);
    wr_reg(4'd3, 32'h2000);
    wr_reg(4'd4, 32'h3);
    wr_reg(4'd5, 32'h3);
    wr_reg(4'd6, 32'h11223344);
    wr_reg(4'd7, 32'hA5A55A5A);
    wr_reg(4'd8, 32'h0);
    wr_reg(4'd9, 32'h0000FF00);
    wr_reg(4'd0, 32'h7FF);  // both channels paired, mode 11, all directions

    for (int k = 0; k < NV; k++) begin
      xfer(VEC[k].a, VEC[k].d, VEC[k].sz, VEC[k].wr);
      chk($sformatf("R4 R7 R8 vector %0d", k), {30'd0, brk_pulse}, {30'd0, VEC[k].exp});
    end

    // R11 sticky and write-1-clear
    chk("R11 sticky set", {30'd0, brk_sticky}, 32'd3);
    wr_reg(4'd1, 32'h1);
    chk("R11 clear ch0 only", {30'd0, brk_sticky}, 32'd2);
    wr_reg(4'd1, 32'h0);
    chk("R11 zero write no effect", {30'd0, brk_sticky}, 32'd2);
    wr_reg(4'd1, 32'h2);
    chk("R11 clear ch1", {30'd0, brk_sticky}, 32'd0);

    // R2 strobe gating and single-cycle pulse
    @(negedge clk);
    xfer_addr = 32'h1000; xfer_data = 32'h11223344; xfer_size = 2'b10; xfer_valid = 1'b0;
    @(negedge clk);
    chk("R2 no strobe no pulse", {30'd0, brk_pulse}, 32'd0);
    xfer(32'h1000, 32'h11223344, 2'b10, 1'b0);
    chk("R2 pulse next cycle", {30'd0, brk_pulse}, 32'd1);
    @(negedge clk);
    chk("R2 pulse one cycle wide", {30'd0, brk_pulse}, 32'd0);

    // R11 hit wins over simultaneous clear
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd1; cfg_wdata = 32'h1;
    xfer_valid = 1'b1; xfer_addr = 32'h1000; xfer_data = 32'h11223344; xfer_size = 2'b10;
    @(negedge clk);
    cfg_we = 1'b0; xfer_valid = 1'b0;
    chk("R11 set wins over clear", {30'd0, brk_sticky}, 32'd1);

    // R4 address-only cases: data registers ignored
    wr_reg(4'd0, 32'h6FF);  // combine off
    xfer(32'h1000, 32'hDEADBEEF, 2'b10, 1'b0);
    chk("R4 combine off", {30'd0, brk_pulse}, 32'd1);
    wr_reg(4'd0, 32'h5FF);  // mode 10
    xfer(32'h1000, 32'hDEADBEEF, 2'b10, 1'b0);
    chk("R4 mode not 11", {30'd0, brk_pulse}, 32'd1);
    wr_reg(4'd0, 32'h7FD);  // ch0 data enable off
    xfer(32'h1000, 32'hDEADBEEF, 2'b10, 1'b0);
    chk("R4 data enable off", {30'd0, brk_pulse}, 32'd1);
    xfer(32'h2000, 32'hDEADBEEF, 2'b10, 1'b0);
    chk("R4 ch1 still paired", {30'd0, brk_pulse}, 32'd0);

    // R10 direction field
    wr_reg(4'd0, 32'h7F7);  // ch0 reads only
    xfer(32'h1000, 32'h11223344, 2'b10, 1'b1);
    chk("R10 write blocked", {30'd0, brk_pulse}, 32'd0);
    xfer(32'h1000, 32'h11223344, 2'b10, 1'b0);
    chk("R10 read allowed", {30'd0, brk_pulse}, 32'd1);
    wr_reg(4'd0, 32'h7F3);  // ch0 direction 00
    xfer(32'h1000, 32'h11223344, 2'b10, 1'b0);
    chk("R10 none allowed", {30'd0, brk_pulse}, 32'd0);

    // R3 address mask
    wr_reg(4'd0, 32'h7FF);
    wr_reg(4'd4, 32'hF3);
    xfer(32'h10A0, 32'h11223344, 2'b10, 1'b0);
    chk("R3 masked bits ignored", {30'd0, brk_pulse}, 32'd1);
    xfer(32'h1100, 32'h11223344, 2'b10, 1'b0);
    chk("R3 unmasked bit compared", {30'd0, brk_pulse}, 32'd0);

    // R9 reserved size acts as word
    xfer(32'h1000, 32'h11223344, 2'b11, 1'b0);
    chk("R9 reserved size match", {30'd0, brk_pulse}, 32'd1);
    xfer(32'h1000, 32'h11000000, 2'b11, 1'b0);
    chk("R9 reserved size full compare", {30'd0, brk_pulse}, 32'd0);

    // R6 extra data mask bits
    wr_reg(4'd8, 32'h000000FF);
    xfer(32'h1000, 32'h11223300, 2'b10, 1'b0);
    chk("R6 extra mask", {30'd0, brk_pulse}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule